// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame is kept, based on its identifier, its frame-type flags and a bank of programmable acceptance and mask bytes. The receive path presents the raw identifier with its IDE and RTR flags and a one-cycle valid strobe. The block packs these into a four-byte identifier word. It compares that word against the filter bank and reports, one clock later, whether any filter matched and which filter was the lowest-numbered match.

The bank of eight acceptance bytes and eight mask bytes can be arranged as two filters of four bytes, four filters of two bytes, or eight filters of one byte. A fourth setting closes the filter. In every arrangement a mask bit of 1 removes the corresponding identifier bit from the comparison. A mask bit of 0 requires that bit to equal the acceptance bit. This lets one filter accept a single identifier, or a whole range when its low bits are masked. While the controller is held in initialization, the filter is idle and produces no result.

Top module: `caf_accept_filter`

## Requirements
- R1: While reset is high, `res_valid_o`, `accept_o` and `hit_idx_o` are all zero, even with a matching identifier strobed.
- R2: `res_valid_o` is high in exactly the cycle after a cycle in which `id_valid_i` was high and `init_mode_i` was low. With no strobe, all three outputs return to zero.
- R3: For every slot byte, a mask bit of 1 makes that identifier bit a don't-care. A mask bit of 0 requires the identifier bit to equal the acceptance bit.
- R4: With `arr_mode_i` = 2'b00, filter k (k = 0, 1) compares all four packed identifier bytes. Packed byte b is compared with acceptance/mask byte 4k+b.
- R5: With `arr_mode_i` = 2'b01, filter k (k = 0..3) compares packed bytes 0 and 1 with acceptance/mask bytes 2k and 2k+1.
- R6: With `arr_mode_i` = 2'b10, filter k (k = 0..7) compares only packed byte 0 (the top eight identifier bits) with acceptance/mask byte k.
- R7: For a standard frame (`ide_i` = 0), the packed bytes are built as follows. Byte 0 is id[10:3]. Byte 1 is {id[2:0], RTR, 0, 3'b000}. Bytes 2 and 3 are zero.
- R8: For an extended frame (`ide_i` = 1), the packed bytes are built as follows. Byte 0 is id[28:21]. Byte 1 is {id[20:18], 1, 1, id[17:15]}. Byte 2 is id[14:7]. Byte 3 is {id[6:0], RTR}.
- R9: `accept_o` is high when any filter of the current arrangement matches. `hit_idx_o` then gives the lowest-numbered matching filter, and it is zero whenever `accept_o` is low.
- R10: While `init_mode_i` is high, a strobed identifier produces neither `res_valid_o` nor `accept_o`.
- R11: With `arr_mode_i` = 2'b11 the filter is closed: a strobe yields `res_valid_o` with `accept_o` low.
- R12: Masking packed byte 0 bit 0 and packed byte 1 bits 7:5 on a standard-identifier filter accepts all of 0x120..0x12F from a 0x120 pattern, and nothing outside that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| init_mode_i | input | 1 | Controller in initialization; filter idle |
| arr_mode_i | input | 2 | Filter arrangement: 00 two wide, 01 four half, 10 eight byte, 11 closed |
| acc_bytes_i | input | 8*FILTER_BYTES | Acceptance bytes, byte j at bits [8j+7:8j] |
| mask_bytes_i | input | 8*FILTER_BYTES | Mask bytes, byte j at bits [8j+7:8j]; 1 = don't care |
| id_valid_i | input | 1 | Identifier strobe, one cycle per frame |
| id_i | input | 29 | Identifier; standard frames use bits 10:0 |
| ide_i | input | 1 | Extended identifier flag |
| rtr_i | input | 1 | Remote request flag |
| res_valid_o | output | 1 | Result strobe, one cycle after `id_valid_i` |
| accept_o | output | 1 | Frame accepted |
| hit_idx_o | output | $clog2(FILTER_BYTES) | Lowest matching filter |

## Verification
The bench builds the block with the default FILTER_BYTES = 8. With that value, each of the three arrangements uses its full set of filters: two wide, four half and eight byte filters. The highest indices (1, 3 and 7) and the priority between overlapping filters can therefore all be reached. Directed frames cover the packing of both identifier formats, the RTR and IDE bit positions, masked ranges, the idle and closed states, and mixed random configurations whose expectations come from a bench-side model.

// File: rtl/caf_pkg.sv
package caf_pkg;

  typedef enum logic [1:0] {
    ARR_WIDE = 2'b00,
    ARR_HALF = 2'b01,
    ARR_BYTE = 2'b10,
    ARR_OFF  = 2'b11
  } caf_arr_e;

  localparam int ID_BYTES   = 4;
  localparam int EXT_ID_W   = 29;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = ID_BYTES * BYTE_W;

endpackage

// File: rtl/caf_id_pack.sv
module caf_id_pack
  import caf_pkg::*;
(
  input  logic [EXT_ID_W-1:0] id_i,
  input  logic                ide_i,
  input  logic                rtr_i,
  output logic [WORD_W-1:0]   word_o
);

  always_comb begin
    if (ide_i) begin
      word_o[31:24] = id_i[28:21];
      word_o[23:16] = {id_i[20:18], 1'b1, 1'b1, id_i[17:15]};
      word_o[15:8]  = id_i[14:7];
      word_o[7:0]   = {id_i[6:0], rtr_i};
    end else begin
      word_o[31:24] = id_i[10:3];
      word_o[23:16] = {id_i[2:0], rtr_i, 1'b0, 3'b000};
      word_o[15:0]  = 16'h0000;
    end
  end

endmodule

// File: rtl/caf_slot_match.sv
module caf_slot_match
  import caf_pkg::*;
#(
  parameter int FILTER_BYTES = 8
) (
  input  logic [WORD_W-1:0]           word_i,
  input  caf_arr_e                    arr_i,
  input  logic [8*FILTER_BYTES-1:0]   acc_i,
  input  logic [8*FILTER_BYTES-1:0]   msk_i,
  output logic [FILTER_BYTES-1:0]     slot_eq_o
);

  for (genvar j = 0; j < FILTER_BYTES; j++) begin : g_slot
    localparam int POS4 = j % 4;
    localparam int POS2 = j % 2;
    logic [BYTE_W-1:0] pick;
    logic [BYTE_W-1:0] diff;

    always_comb begin
      case (arr_i)
        ARR_WIDE: pick = word_i[BYTE_W*(3-POS4) +: BYTE_W];
        ARR_HALF: pick = word_i[BYTE_W*(3-POS2) +: BYTE_W];
        default:  pick = word_i[WORD_W-1 -: BYTE_W];
      endcase
      diff         = (pick ^ acc_i[BYTE_W*j +: BYTE_W]) & ~msk_i[BYTE_W*j +: BYTE_W];
      slot_eq_o[j] = (diff == '0);
    end
  end

endmodule

// File: rtl/caf_hit_select.sv
module caf_hit_select
  import caf_pkg::*;
#(
  parameter int FILTER_BYTES = 8,
  localparam int IDX_W = $clog2(FILTER_BYTES)
) (
  input  logic [FILTER_BYTES-1:0] slot_eq_i,
  input  caf_arr_e                arr_i,
  output logic                    any_o,
  output logic [IDX_W-1:0]        idx_o
);

  localparam int N_WIDE = FILTER_BYTES / 4;
  localparam int N_HALF = FILTER_BYTES / 2;

  logic [FILTER_BYTES-1:0] wide_hit;
  logic [FILTER_BYTES-1:0] half_hit;
  logic [FILTER_BYTES-1:0] hit_vec;

  for (genvar f = 0; f < FILTER_BYTES; f++) begin : g_filt
    if (f < N_WIDE) begin : g_wide
      assign wide_hit[f] = &slot_eq_i[4*f +: 4];
    end else begin : g_wide_none
      assign wide_hit[f] = 1'b0;
    end
    if (f < N_HALF) begin : g_half
      assign half_hit[f] = &slot_eq_i[2*f +: 2];
    end else begin : g_half_none
      assign half_hit[f] = 1'b0;
    end
  end

  always_comb begin
    case (arr_i)
      ARR_WIDE: hit_vec = wide_hit;
      ARR_HALF: hit_vec = half_hit;
      ARR_BYTE: hit_vec = slot_eq_i;
      default:  hit_vec = '0;
    endcase
  end

  always_comb begin
    idx_o = '0;
    for (int f = FILTER_BYTES - 1; f >= 0; f--) begin
      if (hit_vec[f]) idx_o = IDX_W'(f);
    end
    any_o = |hit_vec;
  end

endmodule

// File: rtl/caf_accept_filter.sv
module caf_accept_filter
  import caf_pkg::*;
#(
  parameter int FILTER_BYTES = 8,
  localparam int IDX_W = $clog2(FILTER_BYTES),
  localparam int BANK_W = 8 * FILTER_BYTES
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                init_mode_i,
  input  logic [1:0]          arr_mode_i,
  input  logic [BANK_W-1:0]   acc_bytes_i,
  input  logic [BANK_W-1:0]   mask_bytes_i,
  input  logic                id_valid_i,
  input  logic [28:0]         id_i,
  input  logic                ide_i,
  input  logic                rtr_i,
  output logic                res_valid_o,
  output logic                accept_o,
  output logic [IDX_W-1:0]    hit_idx_o
);

  caf_arr_e                arr;
  logic [WORD_W-1:0]       id_word;
  logic [FILTER_BYTES-1:0] slot_eq;
  logic                    any_hit;
  logic [IDX_W-1:0]        first_idx;
  logic                    live;

  assign arr  = caf_arr_e'(arr_mode_i);
  assign live = id_valid_i & ~init_mode_i;

  caf_id_pack u_pack (
    .id_i   (id_i),
    .ide_i  (ide_i),
    .rtr_i  (rtr_i),
    .word_o (id_word)
  );

  caf_slot_match #(.FILTER_BYTES(FILTER_BYTES)) u_slots (
    .word_i    (id_word),
    .arr_i     (arr),
    .acc_i     (acc_bytes_i),
    .msk_i     (mask_bytes_i),
    .slot_eq_o (slot_eq)
  );

  caf_hit_select #(.FILTER_BYTES(FILTER_BYTES)) u_select (
    .slot_eq_i (slot_eq),
    .arr_i     (arr),
    .any_o     (any_hit),
    .idx_o     (first_idx)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      res_valid_o <= 1'b0;
      accept_o    <= 1'b0;
      hit_idx_o   <= '0;
    end else begin
      res_valid_o <= live;
      accept_o    <= live & any_hit;
      hit_idx_o   <= (live & any_hit) ? first_idx : '0;
    end
  end

  assert_strobe_latency_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (id_valid_i && !init_mode_i) |=> res_valid_o);

  assert_quiet_without_strobe_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !id_valid_i |=> (!res_valid_o && !accept_o));

  assert_wide_index_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (arr_mode_i == 2'b00) |=> (int'(hit_idx_o) < FILTER_BYTES / 4));

  assert_half_index_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (arr_mode_i == 2'b01) |=> (int'(hit_idx_o) < FILTER_BYTES / 2));

  assert_accept_has_strobe_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    accept_o |-> res_valid_o);

  assert_index_zero_on_miss_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !accept_o |-> (hit_idx_o == '0));

  assert_init_idle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    init_mode_i |=> (!res_valid_o && !accept_o));

  assert_closed_rejects_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    (arr_mode_i == 2'b11) |=> !accept_o);

endmodule

// File: tb/caf_accept_filter_bench.sv
module caf_accept_filter_bench;

  typedef struct packed {
    logic       v;
    logic       a;
    logic [2:0] h;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst;
  logic        init_mode;
  logic [1:0]  arr_mode;
  logic [63:0] acc;
  logic [63:0] msk;
  logic        id_valid;
  logic [28:0] id;
  logic        ide;
  logic        rtr;
  logic        res_valid;
  logic        accept;
  logic [2:0]  hit_idx;

  int    checks = 0;
  int    errors = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  caf_accept_filter u_caf_accept_filter (
    .clk_i        (clk),
    .rst_i        (rst),
    .init_mode_i  (init_mode),
    .arr_mode_i   (arr_mode),
    .acc_bytes_i  (acc),
    .mask_bytes_i (msk),
    .id_valid_i   (id_valid),
    .id_i         (id),
    .ide_i        (ide),
    .rtr_i        (rtr),
    .res_valid_o  (res_valid),
    .accept_o     (accept),
    .hit_idx_o    (hit_idx)
  );

  // packed identifier word per R7 / R8, byte 0 in the top bits
  function automatic logic [31:0] pkv(logic [28:0] i, logic e, logic r);
    if (e) return {i[28:21], i[20:18], 2'b11, i[17:15], i[14:7], i[6:0], r};
    return {i[10:3], i[2:0], r, 1'b0, 3'b000, 16'h0000};
  endfunction

  function automatic exp_t model(logic v, logic in, logic [1:0] md,
                                 logic [63:0] a, logic [63:0] m,
                                 logic [28:0] i, logic e, logic r);
    exp_t x;
    logic [31:0] p;
    int bpf, nf, j;
    logic ok;
    x = '0;
    if (!v || in) return x;
    x.v = 1'b1;
    if (md == 2'b11) return x;
    p   = pkv(i, e, r);
    bpf = (md == 2'b00) ? 4 : (md == 2'b01) ? 2 : 1;
    nf  = 8 / bpf;
    for (int f = nf - 1; f >= 0; f--) begin
      ok = 1'b1;
      for (int b = 0; b < bpf; b++) begin
        j = f * bpf + b;
        if (((p[31-8*b -: 8] ^ a[8*j +: 8]) & ~m[8*j +: 8]) != 8'h00) ok = 1'b0;
      end
      if (ok) begin
        x.a = 1'b1;
        x.h = 3'(f);
      end
    end
    return x;
  endfunction

  task automatic fill(logic [7:0] a, logic [7:0] m);
    for (int j = 0; j < 8; j++) begin
      acc[8*j +: 8] = a;
      msk[8*j +: 8] = m;
    end
  endtask

  task automatic setb(int j, logic [7:0] a, logic [7:0] m);
    acc[8*j +: 8] = a;
    msk[8*j +: 8] = m;
  endtask

  task automatic set32(int k, logic [31:0] p, logic [31:0] m);
    for (int b = 0; b < 4; b++) setb(4*k + b, p[31-8*b -: 8], m[31-8*b -: 8]);
  endtask

  task automatic set16(int k, logic [15:0] p, logic [15:0] m);
    for (int b = 0; b < 2; b++) setb(2*k + b, p[15-8*b -: 8], m[15-8*b -: 8]);
  endtask

  task automatic quiet();
    @(negedge clk);
    id_valid = 1'b0;
    exp_q.push_back('0);
    tag_q.push_back("R2 idle cycle");
  endtask

  task automatic send(logic [28:0] i, logic e, logic r,
                      logic ev, logic ea, logic [2:0] eh, string tag);
    exp_t x;
    @(negedge clk);
    id = i; ide = e; rtr = r; id_valid = 1'b1;
    x.v = ev; x.a = ea; x.h = eh;
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  task automatic rsend(logic v, logic [28:0] i, logic e, logic r);
    @(negedge clk);
    id = i; ide = e; rtr = r; id_valid = v;
    exp_q.push_back(model(v, init_mode, arr_mode, acc, msk, i, e, r));
    tag_q.push_back("R2 R3 R9 random frame");
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #2;
    if (exp_q.size() != 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (res_valid !== e.v || accept !== e.a || hit_idx !== e.h) begin
        errors++;
        $display("FAIL %s: got v=%0b a=%0b h=%0d expected v=%0b a=%0b h=%0d",
                 t, res_valid, accept, hit_idx, e.v, e.a, e.h);
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; init_mode = 1'b0; arr_mode = 2'b10;
    fill(8'hFF, 8'h00);
    setb(5, 8'h24, 8'h00);
    id = 29'h123; ide = 1'b0; rtr = 1'b0; id_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || accept !== 1'b0 || hit_idx !== 3'd0) begin
      errors++;
      $display("FAIL R1 reset: got v=%0b a=%0b h=%0d expected v=0 a=0 h=0",
               res_valid, accept, hit_idx);
    end
    rst = 1'b0; id_valid = 1'b0;

    // eight byte filters
    send(29'h123, 0, 0, 1, 1, 3'd5, "R6 byte filter on top bits");
    send(29'h12F, 0, 0, 1, 0, 3'd0, "R3 mask zero compares");
    quiet(); setb(5, 8'h24, 8'h01);
    send(29'h12F, 0, 0, 1, 1, 3'd5, "R3 mask one ignores bit");
    quiet(); setb(2, 8'h24, 8'h00);
    send(29'h123, 0, 0, 1, 1, 3'd2, "R9 lowest filter wins");
    send(29'h4801234, 1, 1, 1, 1, 3'd2, "R6 R8 extended top byte");
    quiet();

    // two wide filters
    quiet(); arr_mode = 2'b00; fill(8'h00, 8'h00);
    set32(0, pkv(29'h1, 1, 0), 32'h0);
    set32(1, pkv(29'h1ABCDE5, 1, 0), 32'h0);
    send(29'h1ABCDE5, 1, 0, 1, 1, 3'd1, "R4 R8 wide filter 1");
    send(29'h1ABCDE5, 1, 1, 1, 0, 3'd0, "R8 RTR bit compared");
    send(29'h1ABCDE5 ^ 29'h4000, 1, 0, 1, 0, 3'd0, "R4 byte 2 compared");
    send(29'h1, 1, 0, 1, 1, 3'd0, "R4 wide filter 0");
    send(29'h123, 0, 0, 1, 0, 3'd0, "R7 standard vs extended pattern");
    quiet(); set32(1, pkv(29'h1ABCDE5, 1, 0), 32'h0000_0001);
    send(29'h1ABCDE5, 1, 1, 1, 1, 3'd1, "R3 masked RTR");

    // four half filters
    quiet(); arr_mode = 2'b01; fill(8'hFF, 8'h00);
    set16(3, pkv(29'h123, 0, 0) >> 16, 16'h0);
    send(29'h123, 0, 0, 1, 1, 3'd3, "R5 R7 half filter 3");
    send(29'h123, 0, 1, 1, 0, 3'd0, "R7 RTR bit position");
    send(29'h048C0000, 1, 0, 1, 0, 3'd0, "R7 IDE bit position");
    quiet(); set16(1, pkv(29'h120, 0, 0) >> 16, 16'h01E0);
    send(29'h120, 0, 0, 1, 1, 3'd1, "R12 range low end");
    send(29'h12F, 0, 0, 1, 1, 3'd1, "R12 range high end");
    send(29'h123, 0, 0, 1, 1, 3'd1, "R9 R12 overlap picks filter 1");
    send(29'h130, 0, 0, 1, 0, 3'd0, "R12 above range");
    send(29'h11F, 0, 0, 1, 0, 3'd0, "R12 below range");

    // idle and closed
    quiet(); init_mode = 1'b1;
    send(29'h123, 0, 0, 0, 0, 3'd0, "R10 init mode idle");
    send(29'h120, 0, 0, 0, 0, 3'd0, "R10 init mode idle");
    quiet(); init_mode = 1'b0; arr_mode = 2'b11;
    send(29'h123, 0, 0, 1, 0, 3'd0, "R11 closed filter");
    quiet(); arr_mode = 2'b01;
    send(29'h123, 0, 0, 1, 1, 3'd1, "R11 reopened");

    // random configurations against the model
    for (int it = 0; it < 120; it++) begin
      quiet();
      arr_mode  = 2'($urandom);
      init_mode = ($urandom % 8) == 0;
      acc = {$urandom, $urandom};
      msk = {$urandom | $urandom, $urandom | $urandom};
      for (int s = 0; s < 3; s++)
        rsend(($urandom % 4) != 0, 29'($urandom), 1'($urandom), 1'($urandom));
    end
    init_mode = 1'b0;
    quiet(); quiet();
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule